// File: doc/BRIEF.md
# FIFO Drain Handshake Controller

This block sits on the read side of an asynchronous-style handshake FIFO, one that shifts words in and out on strobes. It generates the shift-out strobe towards the FIFO and hands each word it removes to a downstream sink. The FIFO reports that a word is waiting on its output-ready line. The controller raises the shift-out strobe only while that line is high and holds the strobe until the line drops. It then releases the strobe, which advances the FIFO's read side. The word is captured on the same clock edge that raises the strobe, and a one-cycle valid pulse marks it for the sink.

Right after the first word lands in an empty FIFO, output-ready goes high, but for a short time the FIFO does not see shift-out strobes. The controller keeps its own occupancy count from the shift-in strobe and input-ready line that it observes on the write side. When the count shows the FIFO was empty, it arms a guard. The first launch then waits until output-ready has stayed high for a set number of cycles. Later words that arrive while the FIFO still holds data get no such wait. A mode input makes the controller hold off draining until more than half the FIFO is occupied. Once draining has started in that mode, it continues until the FIFO is empty. A sink-ready input must be high before each new strobe starts.

Top module: `fifo_drain_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, fifo_shout and word_vld are 0, word_out is all zeros, the occupancy count is 0 and the guard is armed.
- R2: Words reach word_out in the order they entered the FIFO. word_vld is high for exactly one cycle per word, and word_out changes only in a cycle where word_vld is high.
- R3: fifo_shout rises only in the cycle after fifo_ordy was sampled high. word_out takes the value fifo_dout had at that same edge.
- R4: Once raised, fifo_shout stays high until fifo_ordy has been sampled low, and then falls. Each strobe removes exactly one word and never reads an empty FIFO.
- R5: For the first word written into an empty FIFO, including the first word after reset, fifo_shout does not rise until fifo_ordy has been high for at least GUARD_CYC+1 cycles.
- R6: Words that arrive while the count is nonzero get no guard wait. The next strobe starts on the first edge at which fifo_ordy is seen high again (2 cycles or fewer after it rises).
- R7: While sink_rdy is low, no new strobe starts and word_vld stays 0. Held words are delivered once sink_rdy returns high.
- R8: With half_mode high, no strobe starts while the count is DEPTH/2 or less. Once the count exceeds DEPTH/2, strobes continue until the count reaches 0.
- R9: The count increases on each rising edge of fifo_shin that occurs while fifo_irdy is high, and decreases on each strobe launch. It saturates at 0 and DEPTH. A shift-in while fifo_irdy is low is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_mode | input | 1 | 1 = wait for more than half occupancy before draining |
| sink_rdy | input | 1 | Downstream sink can accept a new word |
| fifo_ordy | input | 1 | FIFO output-ready flag |
| fifo_irdy | input | 1 | FIFO input-ready flag (observed) |
| fifo_shin | input | 1 | FIFO shift-in strobe (observed) |
| fifo_dout | input | WIDTH | FIFO output word |
| fifo_shout | output | 1 | Shift-out strobe to the FIFO (registered) |
| word_out | output | WIDTH | Captured word |
| word_vld | output | 1 | One-cycle pulse marking a new word_out |

## Verification
On every cycle the assertions check the strobe-versus-flag protocol. A strobe rises only after output-ready was high and falls only after it was low. They also check that the strobe holds while the valid pulse is out, that the valid pulse is isolated, that the captured word is stable between pulses, that sink-ready gates each launch, that the count stays within its bound, and that the reset state is correct. The guard wait only on the first word after empty, the FIFO-order delivery, the half-full hold-off with its drain-to-empty behaviour, and the refusal to count writes to a full FIFO all depend on word history. The bench's scenarios against a behavioural FIFO model show these.

// File: rtl/fdh_pkg.sv
package fdh_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } strobe_st_t;
endpackage

// File: rtl/fdh_occupancy.sv
module fdh_occupancy #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shin,
  input  logic          irdy,
  input  logic          take,
  output logic [CW-1:0] occ,
  output logic          above_half
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [CW-1:0] HALFV = CW'(DEPTH / 2);

  logic shin_q;
  logic add;

  assign add = shin && !shin_q && irdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      shin_q     <= 1'b0;
      occ        <= '0;
      above_half <= 1'b0;
    end else begin
      shin_q <= shin;
      case ({add, take})
        2'b10:   if (occ != FULLV) occ <= occ + 1'b1;
        2'b01:   if (occ != '0)    occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      if (occ > HALFV)      above_half <= 1'b1;
      else if (occ == '0)   above_half <= 1'b0;
    end
  end
endmodule

// File: rtl/fdh_guard.sv
module fdh_guard #(
  parameter int GUARD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ordy,
  input  logic occ_zero,
  input  logic take,
  output logic guard_ok
);
  generate
    if (GUARD_CYC == 0) begin : g_none
      assign guard_ok = 1'b1;
    end else begin : g_timer
      localparam int GW = $clog2(GUARD_CYC + 1);
      localparam logic [GW-1:0] LIMIT = GW'(GUARD_CYC);
      logic          armed;
      logic [GW-1:0] gcnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          armed <= 1'b1;
          gcnt  <= '0;
        end else begin
          if (take)          armed <= 1'b0;
          else if (occ_zero) armed <= 1'b1;
          if (!armed || !ordy || take) gcnt <= '0;
          else if (gcnt != LIMIT)      gcnt <= gcnt + 1'b1;
        end
      end

      assign guard_ok = !armed || (gcnt == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/fdh_strobe.sv
module fdh_strobe
  import fdh_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ordy,
  input  logic             sink_rdy,
  input  logic             permit,
  input  logic [WIDTH-1:0] dout,
  output logic             so,
  output logic [WIDTH-1:0] word,
  output logic             vld,
  output logic             take
);
  strobe_st_t st;

  assign take = (st == ST_IDLE) && ordy && sink_rdy && permit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      so   <= 1'b0;
      word <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= 1'b0;
      case (st)
        ST_IDLE: if (take) begin
          st   <= ST_HOLD;
          so   <= 1'b1;
          word <= dout;
          vld  <= 1'b1;
        end
        ST_HOLD: if (!ordy) begin
          st <= ST_IDLE;
          so <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fifo_drain_ctrl.sv
module fifo_drain_ctrl #(
  parameter int WIDTH     = 5,
  parameter int DEPTH     = 64,
  parameter int GUARD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_mode,
  input  logic             sink_rdy,
  input  logic             fifo_ordy,
  input  logic             fifo_irdy,
  input  logic             fifo_shin,
  input  logic [WIDTH-1:0] fifo_dout,
  output logic             fifo_shout,
  output logic [WIDTH-1:0] word_out,
  output logic             word_vld
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ_q;
  logic          above_half;
  logic          take;
  logic          guard_ok;
  logic          permit;

  fdh_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst(rst), .shin(fifo_shin), .irdy(fifo_irdy),
    .take(take), .occ(occ_q), .above_half(above_half)
  );

  fdh_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk(clk), .rst(rst), .ordy(fifo_ordy), .occ_zero(occ_q == '0),
    .take(take), .guard_ok(guard_ok)
  );

  assign permit = guard_ok && (!half_mode || above_half);

  fdh_strobe #(.WIDTH(WIDTH)) u_strobe (
    .clk(clk), .rst(rst), .ordy(fifo_ordy), .sink_rdy(sink_rdy),
    .permit(permit), .dout(fifo_dout), .so(fifo_shout),
    .word(word_out), .vld(word_vld), .take(take)
  );
endmodule

// File: rtl/fdh_checker.sv
module fdh_checker #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             sink_rdy,
  input logic             fifo_ordy,
  input logic             fifo_shout,
  input logic [WIDTH-1:0] word_out,
  input logic             word_vld,
  input logic [CW-1:0]    occ
);
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!fifo_shout && !word_vld && word_out == '0 && occ == '0));

  a_r2_vld_single: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

  a_r2_word_stable: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_out));

  a_r3_rise_on_ordy: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_shout) |-> $past(fifo_ordy));

  a_r3_vld_with_strobe: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> fifo_shout);

  a_r4_fall_after_ordy_low: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_shout) |-> !$past(fifo_ordy));

  a_r7_sink_gates: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_shout) |-> $past(sink_rdy));

  a_r9_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));
endmodule

bind fifo_drain_ctrl fdh_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .sink_rdy(sink_rdy), .fifo_ordy(fifo_ordy),
  .fifo_shout(fifo_shout), .word_out(word_out), .word_vld(word_vld),
  .occ(occ_q)
);

// File: tb/tb_fifo_drain_ctrl.sv
module tb_fifo_drain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;
  localparam int D = 64;
  localparam int G = 4;

  logic clk = 0, rst = 1, half_mode = 0, sink_rdy = 0;
  logic si = 0;
  logic [W-1:0] din = '0;
  logic fifo_shout, word_vld;
  logic [W-1:0] word_out;

  // behavioural handshake FIFO model
  logic [W-1:0] mem [D];
  int m_cnt = 0, m_rd = 0, m_wr = 0, underflow = 0;
  logic m_or = 0, so_d = 0, si_d = 0;
  logic m_ir;
  logic pop, pu;
  assign m_ir = (m_cnt < D);

  fifo_drain_ctrl #(.WIDTH(W), .DEPTH(D), .GUARD_CYC(G)) dut (
    .clk(clk), .rst(rst), .half_mode(half_mode), .sink_rdy(sink_rdy),
    .fifo_ordy(m_or), .fifo_irdy(m_ir), .fifo_shin(si),
    .fifo_dout(mem[m_rd % D]), .fifo_shout(fifo_shout),
    .word_out(word_out), .word_vld(word_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_rd <= 0; m_wr <= 0; m_or <= 0; so_d <= 0; si_d <= 0;
    end else begin
      pop = so_d && !fifo_shout;
      pu  = si && !si_d && (m_cnt < D);
      if (pop && m_cnt == 0) underflow <= underflow + 1;
      if (pu) mem[m_wr % D] <= din;
      m_wr  <= m_wr + int'(pu);
      m_rd  <= m_rd + int'(pop);
      m_cnt <= m_cnt + int'(pu) - int'(pop);
      m_or  <= !fifo_shout && !pop && ((m_cnt + int'(pu) - int'(pop)) > 0);
      so_d  <= fifo_shout;
      si_d  <= si;
    end
  end

  // monitor
  int errors = 0, checks = 0, cyc = 0;
  int or_cyc = 0, nrise = 0, rx_n = 0, exp_n = 0, bad_vld = 0;
  int deltas [256];
  logic [W-1:0] rx [256];
  logic [W-1:0] expq [256];
  logic or_p = 0, so_p = 0, vld_p = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (m_or && !or_p) or_cyc = cyc;
      if (fifo_shout && !so_p && nrise < 256) begin
        deltas[nrise] = cyc - or_cyc;
        nrise = nrise + 1;
      end
      if (word_vld) begin
        if (vld_p) bad_vld = bad_vld + 1;
        if (rx_n < 256) rx[rx_n] = word_out;
        rx_n = rx_n + 1;
      end
    end
    or_p = m_or; so_p = fifo_shout; vld_p = word_vld;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic clear_log();
    nrise = 0; rx_n = 0; exp_n = 0;
  endtask

  task automatic push(input logic [W-1:0] v);
    @(negedge clk);
    if (m_ir && exp_n < 256) begin expq[exp_n] = v; exp_n++; end
    si = 1; din = v;
    @(negedge clk);
    si = 0;
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 3000 && rx_n < n; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_order(input string tag);
    int bad = 0;
    for (int i = 0; i < exp_n; i++) if (rx[i] !== expq[i]) bad++;
    check(rx_n == exp_n, {tag, " count"}, rx_n, exp_n);
    check(bad == 0, {tag, " order mismatches"}, bad, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    check(fifo_shout == 0, "R1 shout in reset", int'(fifo_shout), 0);
    check(word_vld == 0, "R1 vld in reset", int'(word_vld), 0);
    check(word_out == '0, "R1 word in reset", int'(word_out), 0);
    rst = 0;
    @(negedge clk);
    check(fifo_shout == 0 && word_vld == 0, "R1 idle after reset", int'(fifo_shout), 0);
  endtask

  task automatic t_burst();
    half_mode = 0; sink_rdy = 1; clear_log();
    for (int i = 0; i < 5; i++) push(W'(i * 7 + 3));
    wait_rx(5);
    check_order("R2 burst");
    check(deltas[0] >= G + 1, "R5 first-word guard", deltas[0], G + 1);
    check(deltas[1] <= 2, "R6 no guard when nonempty", deltas[1], 2);
    check(nrise == rx_n, "R4 one strobe per word", nrise, rx_n);
    check(underflow == 0, "R4 no empty read", underflow, 0);
  endtask

  task automatic t_rearm();
    clear_log();
    push(W'(21));
    wait_rx(1);
    check(deltas[0] >= G + 1, "R5 guard rearmed after empty", deltas[0], G + 1);
    check(rx_n == 1 && rx[0] == W'(21), "R3 captured word", int'(rx[0]), 21);
  endtask

  task automatic t_sink_block();
    clear_log(); sink_rdy = 0;
    for (int i = 0; i < 3; i++) push(W'(10 + i));
    repeat (20) @(negedge clk);
    check(rx_n == 0, "R7 no word while sink low", rx_n, 0);
    check(fifo_shout == 0, "R7 no strobe while sink low", int'(fifo_shout), 0);
    sink_rdy = 1;
    wait_rx(3);
    check_order("R7 release");
  endtask

  task automatic t_half();
    clear_log(); half_mode = 1; sink_rdy = 1;
    for (int i = 0; i < D/2; i++) push(W'(i));
    repeat (30) @(negedge clk);
    check(rx_n == 0, "R8 hold at half", rx_n, 0);
    push(W'(30));
    wait_rx(D/2 + 1);
    check_order("R8 drain to empty");
  endtask

  task automatic t_full();
    clear_log(); half_mode = 1; sink_rdy = 0;
    for (int i = 0; i < D + 3; i++) push(W'(i * 3));
    check(m_ir == 0, "R9 FIFO full", int'(m_ir), 0);
    sink_rdy = 1;
    wait_rx(D);
    check_order("R9 full drain");
    clear_log();
    for (int i = 0; i < D/2; i++) push(W'(i + 5));
    repeat (30) @(negedge clk);
    check(rx_n == 0, "R9 count back to zero after full", rx_n, 0);
    push(W'(1));
    wait_rx(D/2 + 1);
    check_order("R9 refill");
    half_mode = 0;
  endtask

  task automatic t_reset_mid();
    clear_log(); sink_rdy = 0;
    for (int i = 0; i < 3; i++) push(W'(17 + i));
    do_reset();
    clear_log(); sink_rdy = 1;
    push(W'(9));
    wait_rx(1);
    check(rx_n == 1 && rx[0] == W'(9), "R1 word after mid reset", int'(rx[0]), 9);
    check(deltas[0] >= G + 1, "R1 guard armed by reset", deltas[0], G + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    do_reset();
    t_burst();
    t_rearm();
    t_sink_block();
    t_half();
    t_full();
    t_reset_mid();
    check(bad_vld == 0, "R2 valid pulses isolated", bad_vld, 0);
    check(underflow == 0, "R4 no empty read overall", underflow, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule